// File: doc/BRIEF.md
# Inverting DC-Blocking High-Pass Filter

This block strips residual DC offset from a stream of signed 24-bit audio samples using a first-order recursive high-pass section, y[n] = x[n] − x[n−1] + a·y[n−1]. The pole a is fixed at 1 − 2^-11 (≈ 0.99951). Because the pole is fixed per sample, the corner frequency follows the sample rate. Each output is the negated filter result, because the datapath inverts polarity. The negation and the rounding saturate to the 24-bit range, so they never wrap.

One sample enters per strobe on `in_valid`, together with a channel tag. Every channel has its own previous-input register and its own previous-output register, and the tag picks which pair a sample uses. The recursion state is kept in fixed point with FRAC_W fractional bits and GUARD_W extra integer bits. The feedback decay is rounded away from zero, so a constant input drives the state down to exactly zero and leaves no limit cycle.

Two pipeline slots carry a sample through the block, and each slot is a two-state machine. In SLOT_IDLE the slot holds nothing. In SLOT_BUSY it holds a sample. A slot takes the fill transition (IDLE→BUSY, or BUSY→BUSY) whenever the stage before it presents a sample. It takes the drain transition (BUSY→IDLE) when that stage is empty. The first slot holds the fresh recursion value, and the per-channel state is written at the same edge. The second slot holds the rounded, negated, saturated output.

Top module: `dc_block_hpf`

## Requirements
- R1: A synchronous active-high `rst` clears every channel's x[n−1] and y[n−1] to zero, drives `out_valid`, `out_chan` and `out_sample` to 0, and returns both slots to SLOT_IDLE. The first sample after reset is therefore filtered from zero state.
- R2: For each accepted sample the internal state is updated as y = (x − xp)·2^8 + yp − dec, where xp and yp are the stored values of the sample's channel and y carries 8 fractional bits. The result is clamped to the signed range ±2^33 (34-bit state).
- R3: The decay term is dec = ceil(yp/2048) when yp ≥ 0 and floor(yp/2048) when yp < 0. This gives a pole of 1 − 2^-11 whose decay is rounded away from zero.
- R4: A constant input on a channel drives that channel's output to exactly 0, and the output then stays at 0.
- R5: `out_sample` = −floor((y + 128)/256), saturated to [−8388608, 8388607]. The output is the negated, rounded recursion value.
- R6: An input of −8388608 applied to zero state yields +8388607. The negation never wraps.
- R7: A sample presented with `in_valid` high in cycle c produces `out_valid` high in cycle c+2. `out_valid` is high in no other cycle.
- R8: Channels keep independent state. Interleaving samples of the other channel does not change a channel's results, and `out_chan` returns the tag of the sample being output.
- R9: A cycle with `in_valid` low changes no channel state and produces no `out_valid` two cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_chan | input | TAG_W (1) | Channel tag of the input sample |
| in_sample | input | DATA_W (24) | Signed input sample |
| out_valid | output | 1 | Output sample strobe |
| out_chan | output | TAG_W (1) | Channel tag of the output sample |
| out_sample | output | DATA_W (24) | Signed, negated filtered sample |

## Verification
Every result is due on the second rising edge after the edge that accepts its sample, and the recursion state a sample uses is already up to date on the next edge. This holds even when the same channel sends samples back to back. The bench drives one stimulus slot per falling edge. It pushes the expectation for that slot into a two-deep queue and compares the outputs against the entry pushed two falling edges earlier, so each comparison falls in the cycle where the result is due. Idle slots enter the queue as "no valid expected", which checks that no output appears for them.

// File: rtl/dc_hpf_pkg.sv
package dc_hpf_pkg;

    // Occupancy of one pipeline slot.
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_e;

    localparam int DEF_DATA_W     = 24;
    localparam int DEF_FRAC_W     = 8;
    localparam int DEF_GUARD_W    = 2;
    localparam int DEF_POLE_SHIFT = 11;
    localparam int DEF_NUM_CH     = 2;

endpackage

// File: rtl/hpf_chan_state.sv
module hpf_chan_state #(
    parameter int NUM_CH = 2,
    parameter int TAG_W  = 1,
    parameter int DATA_W = 24,
    parameter int SW     = 34
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [TAG_W-1:0]         rd_ch,
    output logic signed [DATA_W-1:0] rd_x,
    output logic signed [SW-1:0]     rd_y,
    input  logic                     wr_en,
    input  logic [TAG_W-1:0]         wr_ch,
    input  logic signed [DATA_W-1:0] wr_x,
    input  logic signed [SW-1:0]     wr_y
);

    logic signed [DATA_W-1:0] x_q [NUM_CH];
    logic signed [SW-1:0]     y_q [NUM_CH];

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic hit;
        assign hit = wr_en && (wr_ch == TAG_W'(ch));

        always_ff @(posedge clk) begin
            if (rst) begin
                x_q[ch] <= '0;
                y_q[ch] <= '0;
            end else if (hit) begin
                x_q[ch] <= wr_x;
                y_q[ch] <= wr_y;
            end
        end

        // A channel not addressed by the write keeps its state (R8, R9).
        p_other_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_ch == TAG_W'(ch)) |=> ($stable(x_q[ch]) && $stable(y_q[ch])));
    end

    always_comb begin
        rd_x = '0;
        rd_y = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_ch == TAG_W'(i)) begin
                rd_x = x_q[i];
                rd_y = y_q[i];
            end
        end
    end

endmodule

// File: rtl/hpf_recur.sv
module hpf_recur #(
    parameter int DATA_W     = 24,
    parameter int FRAC_W     = 8,
    parameter int SW         = 34,
    parameter int POLE_SHIFT = 11
) (
    input  logic signed [DATA_W-1:0] x_new,
    input  logic signed [DATA_W-1:0] x_old,
    input  logic signed [SW-1:0]     y_old,
    output logic signed [SW-1:0]     y_new
);

    localparam int CW = SW + 2;

    localparam logic signed [CW-1:0] CEIL_ADD =
        {{(CW-POLE_SHIFT){1'b0}}, {POLE_SHIFT{1'b1}}};
    localparam logic signed [CW-1:0] S_MAX = {{3{1'b0}}, {(SW-1){1'b1}}};
    localparam logic signed [CW-1:0] S_MIN = {{3{1'b1}}, {(SW-1){1'b0}}};
    localparam logic signed [SW-1:0] S_MAX_N = {1'b0, {(SW-1){1'b1}}};
    localparam logic signed [SW-1:0] S_MIN_N = {1'b1, {(SW-1){1'b0}}};

    logic signed [CW-1:0] xn_ext, xo_ext, y_ext;
    logic signed [CW-1:0] diff, diff_fix, decay, sum;

    always_comb begin
        xn_ext   = {{(CW-DATA_W){x_new[DATA_W-1]}}, x_new};
        xo_ext   = {{(CW-DATA_W){x_old[DATA_W-1]}}, x_old};
        y_ext    = {{(CW-SW){y_old[SW-1]}}, y_old};
        diff     = xn_ext - xo_ext;
        diff_fix = diff <<< FRAC_W;
        // Decay rounded away from zero so the state always shrinks (R3).
        if (y_ext[CW-1])
            decay = y_ext >>> POLE_SHIFT;
        else
            decay = (y_ext + CEIL_ADD) >>> POLE_SHIFT;
        sum = diff_fix + y_ext - decay;
        if (sum > S_MAX)
            y_new = S_MAX_N;
        else if (sum < S_MIN)
            y_new = S_MIN_N;
        else
            y_new = sum[SW-1:0];
    end

endmodule

// File: rtl/hpf_out_stage.sv
module hpf_out_stage
    import dc_hpf_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int FRAC_W = 8,
    parameter int SW     = 34,
    parameter int TAG_W  = 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  slot_e                    in_state,
    input  logic [TAG_W-1:0]         in_chan,
    input  logic signed [SW-1:0]     in_y,
    output logic                     out_valid,
    output logic [TAG_W-1:0]         out_chan,
    output logic signed [DATA_W-1:0] out_sample
);

    localparam int CW = SW + 2;

    localparam logic signed [CW-1:0] HALF_LSB =
        {{(CW-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic signed [CW-1:0] O_MAX =
        {{(CW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [CW-1:0] O_MIN =
        {{(CW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [DATA_W-1:0] O_MAX_N = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] O_MIN_N = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic signed [SW-1:0] ONE_LSB =
        {{(SW-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

    slot_e                    state_q, state_d;
    logic signed [CW-1:0]     y_ext, rounded, negated;
    logic signed [DATA_W-1:0] sat_val;

    // Slot transitions: fill when a sample arrives, drain otherwise.
    always_comb begin
        unique case (in_state)
            SLOT_BUSY: state_d = SLOT_BUSY;
            SLOT_IDLE: state_d = SLOT_IDLE;
            default:   state_d = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        y_ext   = {{(CW-SW){in_y[SW-1]}}, in_y};
        rounded = (y_ext + HALF_LSB) >>> FRAC_W;
        negated = -rounded;
        if (negated > O_MAX)
            sat_val = O_MAX_N;
        else if (negated < O_MIN)
            sat_val = O_MIN_N;
        else
            sat_val = negated[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_sample <= '0;
            out_chan   <= '0;
        end else if (in_state == SLOT_BUSY) begin
            out_sample <= sat_val;
            out_chan   <= in_chan;
        end
    end

    assign out_valid = (state_q == SLOT_BUSY);

    // A recursion value of at least one output LSB leaves as a negative sample (R5).
    p_sign_invert_r5: assert property (@(posedge clk) disable iff (rst)
        (in_state == SLOT_BUSY && in_y >= ONE_LSB) |=> (out_valid && out_sample < 0));

endmodule

// File: rtl/dc_block_hpf.sv
module dc_block_hpf
    import dc_hpf_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int FRAC_W     = DEF_FRAC_W,
    parameter int GUARD_W    = DEF_GUARD_W,
    parameter int POLE_SHIFT = DEF_POLE_SHIFT,
    parameter int NUM_CH     = DEF_NUM_CH,
    localparam int TAG_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int SW        = DATA_W + GUARD_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [TAG_W-1:0]  in_chan,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_chan,
    output logic [DATA_W-1:0] out_sample
);

    logic signed [DATA_W-1:0] x_cur, x_prev;
    logic signed [SW-1:0]     y_prev, y_next;
    logic signed [SW-1:0]     s1_y;
    logic [TAG_W-1:0]         s1_chan;
    slot_e                    s1_state, s1_next;
    logic signed [DATA_W-1:0] out_s;

    assign x_cur = in_sample;

    hpf_chan_state #(
        .NUM_CH (NUM_CH),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W),
        .SW     (SW)
    ) u_state (
        .clk   (clk),
        .rst   (rst),
        .rd_ch (in_chan),
        .rd_x  (x_prev),
        .rd_y  (y_prev),
        .wr_en (in_valid),
        .wr_ch (in_chan),
        .wr_x  (x_cur),
        .wr_y  (y_next)
    );

    hpf_recur #(
        .DATA_W     (DATA_W),
        .FRAC_W     (FRAC_W),
        .SW         (SW),
        .POLE_SHIFT (POLE_SHIFT)
    ) u_recur (
        .x_new (x_cur),
        .x_old (x_prev),
        .y_old (y_prev),
        .y_new (y_next)
    );

    // First slot: fill on a strobe, drain otherwise.
    always_comb begin
        unique case (in_valid)
            1'b1:    s1_next = SLOT_BUSY;
            default: s1_next = SLOT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s1_state <= SLOT_IDLE;
        else     s1_state <= s1_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_y    <= '0;
            s1_chan <= '0;
        end else if (in_valid) begin
            s1_y    <= y_next;
            s1_chan <= in_chan;
        end
    end

    hpf_out_stage #(
        .DATA_W (DATA_W),
        .FRAC_W (FRAC_W),
        .SW     (SW),
        .TAG_W  (TAG_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .in_state   (s1_state),
        .in_chan    (s1_chan),
        .in_y       (s1_y),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_sample (out_s)
    );

    assign out_sample = out_s;

    // Fixed two-cycle latency (R7).
    p_valid_late_r7: assert property (@(posedge clk) disable iff (rst)
        ($past(in_valid, 2) && !$past(rst, 2)) |-> out_valid);
    p_no_spurious_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));
    // Tag travels with its sample (R8).
    p_chan_follow_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_chan == $past(in_chan, 2)));
    // With no input change the stored state strictly shrinks toward zero (R4).
    p_dc_shrink_pos_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && x_cur == x_prev && y_prev > 0) |-> (y_next < y_prev && y_next >= 0));
    p_dc_shrink_neg_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && x_cur == x_prev && y_prev < 0) |-> (y_next > y_prev && y_next <= 0));

endmodule

// File: tb/dc_block_hpf_bench.sv
`timescale 1ns/1ps
module dc_block_hpf_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [0:0]  in_chan = '0;
    logic [23:0] in_sample = '0;
    logic        out_valid;
    logic [0:0]  out_chan;
    logic [23:0] out_sample;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    dc_block_hpf u_dc_block_hpf (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_chan    (in_chan),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_chan   (out_chan),
        .out_sample (out_sample)
    );

    // Reference model state per channel.
    longint m_xp [2];
    longint m_y  [2];

    // Two-deep expectation queue.
    logic   e_v [2];
    logic   e_c [2];
    longint e_d [2];
    string  e_r [2];

    function automatic longint model_step(input int ch, input longint x);
        longint d, dec, yn, r, o;
        d = x - m_xp[ch];
        if (m_y[ch] >= 0) dec = (m_y[ch] + 2047) >>> 11;
        else              dec = m_y[ch] >>> 11;
        yn = d * 256 + m_y[ch] - dec;
        if (yn > 64'sd8589934591)  yn = 64'sd8589934591;
        if (yn < -64'sd8589934592) yn = -64'sd8589934592;
        m_xp[ch] = x;
        m_y[ch]  = yn;
        r = (yn + 128) >>> 8;
        o = -r;
        if (o > 8388607)  o = 8388607;
        if (o < -8388608) o = -8388608;
        return o;
    endfunction

    function automatic longint as_signed24(input logic [23:0] v);
        logic signed [23:0] s;
        s = v;
        return longint'(s);
    endfunction

    task automatic check_out();
        longint act;
        act = as_signed24(out_sample);
        checks++;
        if (e_v[1]) begin
            if (!(out_valid === 1'b1 && out_chan === e_c[1] && act == e_d[1])) begin
                errors++;
                $display("FAIL %s: valid=%0b chan=%0d data=%0d expected valid=1 chan=%0d data=%0d",
                         e_r[1], out_valid, out_chan, act, e_c[1], e_d[1]);
            end
        end else begin
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL %s: out_valid=%0b expected 0", e_r[1], out_valid);
            end
        end
    endtask

    task automatic slot(input logic v, input int ch, input longint x, input string req);
        @(negedge clk);
        check_out();
        in_valid  = v;
        in_chan   = 1'(ch);
        in_sample = 24'(x);
        e_v[1] = e_v[0]; e_c[1] = e_c[0]; e_d[1] = e_d[0]; e_r[1] = e_r[0];
        e_v[0] = v;
        e_c[0] = 1'(ch);
        e_d[0] = v ? model_step(ch, x) : 0;
        e_r[0] = req;
    endtask

    task automatic do_reset();
        slot(1'b0, 0, 0, "R7");
        slot(1'b0, 0, 0, "R7");
        @(negedge clk);
        check_out();
        rst = 1'b1;
        in_valid = 1'b0;
        for (int c = 0; c < 2; c++) begin
            m_xp[c] = 0;
            m_y[c]  = 0;
        end
        for (int k = 0; k < 2; k++) begin
            e_v[k] = 1'b0; e_c[k] = 1'b0; e_d[k] = 0; e_r[k] = "R1";
        end
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        for (int c = 0; c < 2; c++) begin
            m_xp[c] = 0;
            m_y[c]  = 0;
        end
        for (int k = 0; k < 2; k++) begin
            e_v[k] = 1'b0; e_c[k] = 1'b0; e_d[k] = 0; e_r[k] = "R1";
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports.
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_sample !== 24'd0 || out_chan !== 1'b0) begin
            errors++;
            $display("FAIL R1: valid=%0b data=%0d chan=%0d expected 0 0 0",
                     out_valid, out_sample, out_chan);
        end

        // R2/R3: varied ramp on channel 0, back to back.
        for (int k = 0; k < 40; k++)
            slot(1'b1, 0, longint'(k) * 37251 - 500000, "R2");
        // R3: small steps where the decay rounding matters.
        for (int k = 0; k < 60; k++)
            slot(1'b1, 0, (k % 3) - 1, "R3");

        // R8: interleaved channels with very different signals.
        for (int k = 0; k < 80; k++) begin
            slot(1'b1, k % 2, (k % 2 == 0) ? ((k % 4 == 0) ? 8388607 : -8388608)
                                           : longint'(k) * 13, "R8");
        end
        // R9: idle gaps between samples, state must be untouched.
        for (int k = 0; k < 30; k++) begin
            slot(1'b1, k % 2, longint'(k) * 99991 - 1500000, "R9");
            for (int g = 0; g < (k % 4); g++)
                slot(1'b0, 0, 777, "R9");
        end

        // R1: reset mid-run clears the state.
        do_reset();
        slot(1'b1, 1, 12345, "R1");
        slot(1'b1, 0, -4000, "R1");

        // R6: most negative input from zero state.
        do_reset();
        slot(1'b1, 0, -8388608, "R6");
        slot(1'b1, 0, 8388607, "R6");
        slot(1'b1, 0, -8388608, "R6");

        // R5: sweep of first-sample responses from zero state.
        for (int p = 0; p < 256; p++) begin
            do_reset();
            slot(1'b1, p % 2, longint'(p) * 65537 - 8388608 + p, "R5");
        end

        // R4: constant input settles to exactly zero.
        do_reset();
        for (int k = 0; k < 13000; k++)
            slot(1'b1, 0, 1000, "R4");
        slot(1'b0, 0, 0, "R4");
        slot(1'b0, 0, 0, "R4");
        checks++;
        if (as_signed24(out_sample) != 0) begin
            errors++;
            $display("FAIL R4: settled output=%0d expected 0", as_signed24(out_sample));
        end

        slot(1'b0, 0, 0, "R7");
        slot(1'b0, 0, 0, "R7");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule